// File: doc/BRIEF.md
# Multi-Port Word Array with Offset Addressing

This block is a memory array with any number of read ports and any number of write ports. Each read port is a plain lookup. Its output follows the current address with no register in the path. Each write port is chosen at elaboration to be either level-driven or edge-driven. An edge-driven port commits on either the rising or the falling transition of its own write clock. Every write is masked bit by bit. Addresses are translated by subtracting a base value, so the array can sit anywhere in a larger address space. Any address that is unknown or that falls outside the window reads as an unknown word, and a write to such an address does nothing.

All state is advanced on one sampling clock `clk`. The write clocks are ordinary inputs that are sampled on that clock. An edge-driven port compares the current sample of its write clock with the previous one. When it sees an active transition, it writes using the address, data and enables held from the previous sample. The reset loads the initial contents from a parameter vector. Setting a read port as registered through `RD_REGISTERED` stops elaboration with an error.

Top module: `mpram`

## Requirements
- R1: The word index is `addr - OFFSET`. A read port raises its `rd_ok` bit and shows word `addr - OFFSET` on its slice `rd_data[p*WIDTH +: WIDTH]` in the same cycle, exactly when `OFFSET <= addr < OFFSET + DEPTH`. Port p's address is `rd_addr[p*ABITS +: ABITS]`.
- R2: A read address that is outside the window, or that holds an unknown bit, drives `rd_ok` low and an all-unknown word.
- R3: A write port whose `WR_CLOCKED` bit is 0 writes at every `clk` edge, using the values present at that edge.
- R4: A port whose `WR_CLOCKED` bit is 1 and whose `WR_RISE` bit is 1 writes only at a `clk` edge where the previous sample of its `wr_clk` bit was 0 and the current sample is 1. Holding the write clock high writes nothing.
- R5: A port whose `WR_CLOCKED` bit is 1 and whose `WR_RISE` bit is 0 writes only where the previous sample was 1 and the current sample is 0.
- R6: An edge-driven write uses the address, data and enables of the sample taken one `clk` cycle before the edge was seen. Values changed at the edge sample are not used.
- R7: Only bits whose enable in `wr_en[p*WIDTH +: WIDTH]` is 1 change. All other bits of the word keep their value.
- R8: A write whose address is outside the window, or unknown, changes no word.
- R9: When several ports write the same bit at one `clk` edge, the highest-numbered port wins.
- R10: While `rst_n` is low, word i bit b takes `INIT[i*WIDTH+b]`. Bits of INIT beyond `DEPTH*WIDTH` are ignored, and missing bits become unknown. The first sample after reset never counts as an active write-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all state |
| rst_n | input | 1 | Active-low synchronous reset, loads INIT |
| wr_clk | input | WR_PORTS | Write clock of each port, one bit per port |
| wr_en | input | WR_PORTS*WIDTH | Bit enables, packed per port |
| wr_addr | input | WR_PORTS*ABITS | Write addresses, packed per port |
| wr_data | input | WR_PORTS*WIDTH | Write data, packed per port |
| rd_addr | input | RD_PORTS*ABITS | Read addresses, packed per port |
| rd_data | output | RD_PORTS*WIDTH | Read words, packed per port |
| rd_ok | output | RD_PORTS | Read address lies inside the window |

## Verification
The bench works on a small array whose window does not start at zero. It sweeps every address on both read ports, so an off-by-one in the offset subtraction shows up as shifted words or as a wrong `rd_ok` at the window edges. Edge-driven ports get their inputs changed at the sampled edge. A design that wrote the post-edge values would store the wrong word. Holding a write clock steady catches a level-sensitive port, and a three-port collision catches a reversed priority. Masked writes and writes outside the window catch merges that disturb bits or words that should stay untouched. A long run with random inputs is checked against a reference array.

// File: rtl/mpram_pkg.sv
`timescale 1ns/1ps
package mpram_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_e;

    // Active transition between two consecutive samples of a write clock.
    function automatic logic edge_seen(edge_e pol, logic was, logic now);
        if (pol == EDGE_RISE) return (was == 1'b0) && (now == 1'b1);
        else                  return (was == 1'b1) && (now == 1'b0);
    endfunction

endpackage

// File: rtl/mpram_addr_map.sv
`timescale 1ns/1ps
module mpram_addr_map #(
    parameter int DEPTH  = 16,
    parameter int ABITS  = 4,
    parameter int OFFSET = 0,
    parameter int IBITS  = 4
) (
    input  logic [ABITS-1:0] addr,
    output logic [IBITS-1:0] idx,
    output logic             hit
);
    localparam int DW = ABITS + 2;
    localparam logic signed [DW-1:0] DEPTH_S  = DW'(DEPTH);
    localparam logic signed [DW-1:0] OFFSET_S = DW'(OFFSET);

    logic signed [DW-1:0] diff;

    always_comb begin
        diff = $signed({2'b00, addr}) - OFFSET_S;
        idx  = diff[IBITS-1:0];
        hit  = !$isunknown(addr) && !diff[DW-1] && (diff < DEPTH_S);
    end
endmodule

// File: rtl/mpram_wr_sel.sv
`timescale 1ns/1ps
module mpram_wr_sel #(
    parameter int ABITS   = 4,
    parameter int WIDTH   = 8,
    parameter bit CLOCKED = 1'b0,
    parameter bit RISE    = 1'b1
) (
    input  logic             clk_now,
    input  logic             clk_was,
    input  logic [ABITS-1:0] addr_now,
    input  logic [ABITS-1:0] addr_was,
    input  logic [WIDTH-1:0] data_now,
    input  logic [WIDTH-1:0] data_was,
    input  logic [WIDTH-1:0] en_now,
    input  logic [WIDTH-1:0] en_was,
    output logic [ABITS-1:0] sel_addr,
    output logic [WIDTH-1:0] sel_data,
    output logic [WIDTH-1:0] sel_en
);
    import mpram_pkg::*;

    localparam edge_e POL = RISE ? EDGE_RISE : EDGE_FALL;

    generate
        if (CLOCKED) begin : g_edge
            logic fire;
            always_comb begin
                fire     = edge_seen(POL, clk_was, clk_now);
                sel_addr = addr_was;
                sel_data = data_was;
                sel_en   = fire ? en_was : '0;
            end
        end else begin : g_level
            logic unused_in;
            always_comb begin
                unused_in = clk_now ^ clk_was ^ (^addr_was) ^ (^data_was) ^ (^en_was);
                sel_addr  = addr_now;
                sel_data  = data_now;
                sel_en    = en_now;
            end
        end
    endgenerate
endmodule

// File: rtl/mpram.sv
`timescale 1ns/1ps
module mpram #(
    parameter int DEPTH    = 16,
    parameter int WIDTH    = 8,
    parameter int ABITS    = 4,
    parameter int OFFSET   = 0,
    parameter int RD_PORTS = 2,
    parameter int WR_PORTS = 2,
    parameter logic [RD_PORTS-1:0] RD_REGISTERED = '0,
    parameter logic [WR_PORTS-1:0] WR_CLOCKED    = '1,
    parameter logic [WR_PORTS-1:0] WR_RISE       = '1,
    parameter int INIT_LEN = DEPTH * WIDTH,
    parameter logic [INIT_LEN-1:0] INIT = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WR_PORTS-1:0]       wr_clk,
    input  logic [WR_PORTS*WIDTH-1:0] wr_en,
    input  logic [WR_PORTS*ABITS-1:0] wr_addr,
    input  logic [WR_PORTS*WIDTH-1:0] wr_data,
    input  logic [RD_PORTS*ABITS-1:0] rd_addr,
    output logic [RD_PORTS*WIDTH-1:0] rd_data,
    output logic [RD_PORTS-1:0]       rd_ok
);
    localparam int IBITS = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [WR_PORTS-1:0]         pclk;
        logic [WR_PORTS*ABITS-1:0]   paddr;
        logic [WR_PORTS*WIDTH-1:0]   pdata;
        logic [WR_PORTS*WIDTH-1:0]   pen;
    } st_t;

    st_t st_d, st_q;

    function automatic st_t reset_state();
        st_t s;
        s = '0;
        for (int i = 0; i < DEPTH; i++) begin
            for (int b = 0; b < WIDTH; b++) begin
                if (i * WIDTH + b < INIT_LEN) s.mem[i][b] = INIT[i * WIDTH + b];
                else                          s.mem[i][b] = 1'bx;
            end
        end
        // Previous sample parked at the active level: no edge on first sample.
        s.pclk = WR_RISE;
        return s;
    endfunction

    generate
        if (RD_REGISTERED != '0) begin : g_bad_cfg
            $error("mpram: registered read ports are not supported");
        end
    endgenerate

    logic [ABITS-1:0] w_addr [WR_PORTS];
    logic [WIDTH-1:0] w_data [WR_PORTS];
    logic [WIDTH-1:0] w_en   [WR_PORTS];
    logic [IBITS-1:0] w_idx  [WR_PORTS];
    logic             w_hit  [WR_PORTS];

    generate
        for (genvar p = 0; p < WR_PORTS; p++) begin : g_wr
            mpram_wr_sel #(
                .ABITS(ABITS), .WIDTH(WIDTH),
                .CLOCKED(WR_CLOCKED[p]), .RISE(WR_RISE[p])
            ) u_sel (
                .clk_now (wr_clk[p]),
                .clk_was (st_q.pclk[p]),
                .addr_now(wr_addr[p*ABITS +: ABITS]),
                .addr_was(st_q.paddr[p*ABITS +: ABITS]),
                .data_now(wr_data[p*WIDTH +: WIDTH]),
                .data_was(st_q.pdata[p*WIDTH +: WIDTH]),
                .en_now  (wr_en[p*WIDTH +: WIDTH]),
                .en_was  (st_q.pen[p*WIDTH +: WIDTH]),
                .sel_addr(w_addr[p]),
                .sel_data(w_data[p]),
                .sel_en  (w_en[p])
            );
            mpram_addr_map #(
                .DEPTH(DEPTH), .ABITS(ABITS), .OFFSET(OFFSET), .IBITS(IBITS)
            ) u_map (
                .addr(w_addr[p]),
                .idx (w_idx[p]),
                .hit (w_hit[p])
            );
        end

        for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
            logic [IBITS-1:0] r_idx;
            logic             r_hit;
            mpram_addr_map #(
                .DEPTH(DEPTH), .ABITS(ABITS), .OFFSET(OFFSET), .IBITS(IBITS)
            ) u_map (
                .addr(rd_addr[r*ABITS +: ABITS]),
                .idx (r_idx),
                .hit (r_hit)
            );
            assign rd_ok[r] = r_hit;
            assign rd_data[r*WIDTH +: WIDTH] = r_hit ? st_q.mem[r_idx] : {WIDTH{1'bx}};
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.pclk  = wr_clk;
        st_d.paddr = wr_addr;
        st_d.pdata = wr_data;
        st_d.pen   = wr_en;
        // Ascending order: a later port overrides an earlier one bit by bit.
        for (int p = 0; p < WR_PORTS; p++) begin
            if (w_hit[p]) begin
                for (int b = 0; b < WIDTH; b++) begin
                    if (w_en[p][b]) st_d.mem[w_idx[p]][b] = w_data[p][b];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end
endmodule

// File: rtl/mpram_chk.sv
`timescale 1ns/1ps
module mpram_chk #(
    parameter int DEPTH    = 16,
    parameter int WIDTH    = 8,
    parameter int ABITS    = 4,
    parameter int OFFSET   = 0,
    parameter int RD_PORTS = 2,
    parameter int WR_PORTS = 2,
    parameter logic [WR_PORTS-1:0] WR_CLOCKED = '1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [WR_PORTS*WIDTH-1:0] wr_en,
    input logic [WR_PORTS*ABITS-1:0] wr_addr,
    input logic [WR_PORTS*WIDTH-1:0] wr_data,
    input logic [RD_PORTS*ABITS-1:0] rd_addr,
    input logic [RD_PORTS*WIDTH-1:0] rd_data,
    input logic [RD_PORTS-1:0]       rd_ok
);
    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < RD_PORTS; p++) begin
                if (!$isunknown(rd_addr[p*ABITS +: ABITS])) begin
                    AST_RD_WINDOW: assert (rd_ok[p] ==
                        ((longint'(rd_addr[p*ABITS +: ABITS]) >= longint'(OFFSET)) &&
                         (longint'(rd_addr[p*ABITS +: ABITS]) < longint'(OFFSET) + longint'(DEPTH))))
                        else $error("read window mismatch on port %0d", p); // R1
                end
            end
            for (int p = 1; p < RD_PORTS; p++) begin
                if (rd_ok[0] && rd_addr[p*ABITS +: ABITS] == rd_addr[0 +: ABITS]) begin
                    AST_RD_PORTS_AGREE: assert (rd_data[p*WIDTH +: WIDTH] === rd_data[0 +: WIDTH])
                        else $error("read ports disagree on one address"); // R1
                end
            end
        end
    end

    generate
        for (genvar p = 0; p < RD_PORTS; p++) begin : g_hold
            AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(wr_en) == '0 && $past(wr_en, 2) == '0 &&
                 $stable(rd_addr[p*ABITS +: ABITS]) && rd_ok[p])
                |-> $stable(rd_data[p*WIDTH +: WIDTH])); // R7
        end

        if (!WR_CLOCKED[0] && WR_PORTS > 1) begin : g_async_land
            AST_ASYNC_LAND: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(wr_en[WIDTH-1:0]) == '1 &&
                 $past(wr_en[WR_PORTS*WIDTH-1:WIDTH]) == '0 &&
                 $past(wr_en[WR_PORTS*WIDTH-1:WIDTH], 2) == '0 &&
                 $past(rd_ok[0]) && $stable(rd_addr[ABITS-1:0]) &&
                 $past(rd_addr[ABITS-1:0]) == $past(wr_addr[ABITS-1:0]))
                |-> rd_data[WIDTH-1:0] == $past(wr_data[WIDTH-1:0])); // R3
        end
    endgenerate
endmodule

bind mpram mpram_chk #(
    .DEPTH(DEPTH), .WIDTH(WIDTH), .ABITS(ABITS), .OFFSET(OFFSET),
    .RD_PORTS(RD_PORTS), .WR_PORTS(WR_PORTS), .WR_CLOCKED(WR_CLOCKED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ok(rd_ok)
);

// File: tb/mpram_tb.sv
`timescale 1ns/1ps
module mpram_tb;
    localparam int D = 12, W = 8, AB = 5, OFS = 6, RP = 2, WP = 3;
    localparam logic [WP-1:0] CLKD = 3'b110;
    localparam logic [WP-1:0] RISE = 3'b010;
    localparam int ILEN = D * W + 8;

    function automatic logic [ILEN-1:0] mk_init();
        logic [ILEN-1:0] v;
        for (int i = 0; i < D; i++) v[i*W +: W] = 8'(8'h30 + 7 * i);
        v[D*W +: 8] = 8'hA5;
        return v;
    endfunction
    localparam logic [ILEN-1:0] INITV = mk_init();

    logic clk = 1'b0, rst_n = 1'b0;
    logic [WP-1:0]    wclk  = 3'b010;
    logic [WP*W-1:0]  wen   = '0, wdata = '0;
    logic [WP*AB-1:0] waddr = '0;
    logic [RP*AB-1:0] raddr = '0;
    logic [RP*W-1:0]  rdata;
    logic [RP-1:0]    rok;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [W-1:0]     mref [D];
    logic [WP-1:0]    pclk;
    logic [WP*AB-1:0] paddr;
    logic [WP*W-1:0]  pdata, pen;

    always #4 clk = ~clk;

    mpram #(
        .DEPTH(D), .WIDTH(W), .ABITS(AB), .OFFSET(OFS), .RD_PORTS(RP), .WR_PORTS(WP),
        .RD_REGISTERED('0), .WR_CLOCKED(CLKD), .WR_RISE(RISE), .INIT_LEN(ILEN), .INIT(INITV)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_clk(wclk), .wr_en(wen), .wr_addr(waddr),
        .wr_data(wdata), .rd_addr(raddr), .rd_data(rdata), .rd_ok(rok)
    );

    task automatic model_commit();
        for (int p = 0; p < WP; p++) begin
            logic [AB-1:0] a;
            logic [W-1:0]  d, e;
            bit go;
            if (CLKD[p]) begin
                go = RISE[p] ? (!pclk[p] && wclk[p]) : (pclk[p] && !wclk[p]);
                a = paddr[p*AB +: AB]; d = pdata[p*W +: W]; e = pen[p*W +: W];
            end else begin
                go = 1'b1;
                a = waddr[p*AB +: AB]; d = wdata[p*W +: W]; e = wen[p*W +: W];
            end
            if (go && int'(a) >= OFS && int'(a) < OFS + D)
                mref[int'(a) - OFS] = (mref[int'(a) - OFS] & ~e) | (d & e);
        end
        pclk = wclk; paddr = waddr; pdata = wdata; pen = wen;
    endtask

    task automatic tick();
        model_commit();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit cond, input string tag, input logic [W:0] act, input logic [W:0] exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_one(input int port, input int a, input string tag);
        bit inwin;
        logic [W-1:0] got;
        inwin = (a >= OFS) && (a < OFS + D);
        got = rdata[port*W +: W];
        if (inwin) check(rok[port] === 1'b1 && got === mref[a - OFS], tag,
                         {rok[port], got}, {1'b1, mref[a - OFS]});
        else       check(rok[port] === 1'b0, tag, {rok[port], 8'h00}, 9'h000);
    endtask

    task automatic sweep(input string tag);
        for (int a = 0; a < 32; a++) begin
            raddr = {5'(31 - a), 5'(a)};
            #0.1;
            read_one(0, a, tag);
            read_one(1, 31 - a, tag);
        end
    endtask

    task automatic word_is(input int a, input logic [W-1:0] exp, input string tag);
        raddr[AB-1:0] = 5'(a);
        #0.1;
        check(rok[0] === 1'b1 && rdata[W-1:0] === exp, tag, {rok[0], rdata[W-1:0]}, {1'b1, exp});
    endtask

    task automatic put(input int p, input int a, input logic [W-1:0] d, input logic [W-1:0] e);
        waddr[p*AB +: AB] = 5'(a);
        wdata[p*W +: W] = d;
        wen[p*W +: W] = e;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < D; i++) mref[i] = INITV[i*W +: W];
        pclk = RISE; paddr = '0; pdata = '0; pen = '0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // Reset contents, offset window, out-of-window reads
        sweep("R10 R1 R2 reset contents and window");
        word_is(6, 8'h30, "R10 first word");
        word_is(17, 8'(8'h30 + 77), "R1 last word");

        // Level-driven port 0
        put(0, 8, 8'h5A, 8'hFF); tick();
        word_is(8, 8'h5A, "R3 async write");
        put(0, 9, 8'hFF, 8'h0F); tick();
        put(0, 0, 8'h00, 8'h00);
        word_is(9, 8'h4F, "R7 partial bits");

        // Rising port 1: set up, then raise clock while changing inputs
        wclk[1] = 1'b0; put(1, 10, 8'hC3, 8'hFF); tick();
        wclk[1] = 1'b1; put(1, 11, 8'h00, 8'hFF); tick();
        word_is(10, 8'hC3, "R4 R6 rising edge uses earlier sample");
        word_is(11, 8'(8'h30 + 35), "R6 post-edge values unused");
        put(1, 14, 8'h77, 8'hFF); tick(); tick(); tick();
        word_is(14, 8'(8'h30 + 56), "R4 clock held high writes nothing");
        put(1, 0, 8'h00, 8'h00); tick();

        // Falling port 2
        wclk[2] = 1'b1; put(2, 12, 8'h3C, 8'hFF); tick();
        wclk[2] = 1'b0; put(2, 13, 8'h99, 8'hFF); tick();
        word_is(12, 8'h3C, "R5 falling edge");
        word_is(13, 8'(8'h30 + 49), "R5 R6 post-edge values unused");
        put(2, 0, 8'h00, 8'h00); tick();

        // Writes outside the window
        put(0, 3, 8'hEE, 8'hFF); tick();
        put(0, 18, 8'hEE, 8'hFF); tick();
        put(0, 31, 8'hEE, 8'hFF); tick();
        put(0, 0, 8'h00, 8'h00); tick();
        sweep("R8 out-of-window writes");

        // Three ports on one word in one cycle
        wclk[1] = 1'b0; wclk[2] = 1'b1;
        put(1, 15, 8'h11, 8'hFF); put(2, 15, 8'h22, 8'hF0); tick();
        wclk[1] = 1'b1; wclk[2] = 1'b0;
        put(0, 15, 8'h33, 8'hFF); put(1, 0, 8'h00, 8'h00); put(2, 0, 8'h00, 8'h00); tick();
        put(0, 0, 8'h00, 8'h00);
        word_is(15, 8'h21, "R9 highest port wins per bit");
        tick();

        // Random run against the reference array
        for (int s = 0; s < 600; s++) begin
            wclk  = 3'($urandom);
            waddr = 15'($urandom);
            wdata = 24'($urandom);
            wen   = 24'($urandom) & ((s % 3 == 0) ? 24'h0 : 24'hFFFFFF);
            tick();
            for (int k = 0; k < 2; k++) begin
                int a;
                a = int'($urandom % 32);
                raddr[AB-1:0] = 5'(a);
                #0.1;
                read_one(0, a, "R1 R9 random reference");
            end
        end
        wen = '0; tick(); tick();
        sweep("R7 R8 final sweep");

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule